// File: doc/BRIEF.md
# Single-Cycle Stack-Machine-Style Processor Core

This block is a small 32-bit processor that completes one whole instruction on every clock edge. Each instruction is fetched, its registers are read, the shared ALU runs, memory is accessed and the results are written back, all in one cycle. The next program counter is then chosen. The core holds eight 32-bit general registers. Register 4 serves as the stack pointer. It also has three condition flags: zero, sign and overflow.

Memory is byte-addressed and little-endian. The core sees it through two combinational windows. The fetch window returns six consecutive bytes starting at the program counter. The data window returns a 32-bit word at the data address and accepts a 32-bit write on the clock edge. Besides moves, loads, stores, arithmetic, jumps, conditional moves and stack operations, the core has a two-byte indexed load. That load adds two registers to form its address and puts the loaded word back into the second register. A halt instruction or an undefined instruction stops the core. After that the program counter, registers and memory stay untouched until reset.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high on a clock edge, the core clears the program counter to 0, sets `run_state` to 0 (running), sets all eight registers to 0, and sets the flags to zero=1, sign=0, overflow=0.
- R2: The first instruction byte holds the opcode in bits 7:4 and the function in bits 3:0. The second byte, where present, holds register A in bits 7:4 and register B in bits 3:0. Register id 15 means "none". Instruction lengths are as follows:
  - 1 byte: opcodes 0, 1 and 9.
  - 2 bytes: opcodes 2, 6, A, B and C.
  - 5 bytes: opcodes 7 and 8. Their 4-byte constant starts at byte 1.
  - 6 bytes: opcodes 3, 4 and 5. Their 4-byte constant starts at byte 2.
  - All constants are little-endian. Any instruction that does not redirect the flow advances the program counter by its length.
- R3: Opcode 6 writes B op A into register B. The function selects the operation: 0 add, 1 subtract (B minus A), 2 and, 3 xor. Opcode 3 loads its constant into register B. Opcode 2 copies A into B.
- R4: Only opcode 6 updates the flags. Zero is set when the result is 0, and sign is the result's top bit. Overflow is the signed overflow of an add or subtract, and it is 0 for and and xor.
- R5: Jumps (opcode 7) and conditional moves (opcode 2) use the function to pick a condition: 0 always, 1 less-or-equal, 2 less, 3 equal, 4 not-equal, 5 greater-or-equal, 6 greater. A taken jump loads the constant into the program counter. A move whose condition is false leaves register B unchanged.
- R6: Opcode 4 stores register A to the address constant + register B. Opcode 5 loads the word at constant + register B into register A. The word's least significant byte sits at the lowest address.
- R7: Opcode C is the indexed load. It loads the word at register A + register B into register B and leaves register A unchanged.
- R8: Push (opcode A) lowers the stack pointer by 4 and stores register A there. Pop (opcode B) loads register A from the old stack pointer and raises it by 4. Call (opcode 8) pushes the address of the next instruction and jumps to its constant. Return (opcode 9) pops the program counter.
- R9: When pop names the stack pointer as its destination, the loaded word wins over the incremented stack pointer.
- R10: Opcode 0 sets `run_state` to 1 and leaves the program counter on the halt instruction. From then on no register, flag or memory write happens and the program counter stays frozen.
- R11: Opcodes D to F are undefined, as are function values above 6 for opcodes 2 and 7 and above 3 for opcode 6. An undefined instruction sets `run_state` to 2, writes nothing and freezes the core just as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Program counter, registered; address of fetch window |
| fetch_bytes | input | 48 | Six bytes at `fetch_addr`, byte k in bits 8k+7:8k |
| data_addr | output | 32 | Byte address of the data word |
| data_rdata | input | 32 | Little-endian word read at `data_addr` |
| data_we | output | 1 | Write the data word on the next rising edge |
| data_wdata | output | 32 | Word to write, little-endian |
| run_state | output | 2 | 0 running, 1 halted, 2 undefined instruction; registered |

## Verification
A pop whose destination is the stack pointer asks for two register writes to the same register on the same edge. One is the stack adjustment from the ALU and the other is the word from the data window. The bench provokes this by pushing a known word and then popping it straight into the stack pointer, and it judges the result by storing the stack pointer to memory. The stored word must be the loaded value, not the old pointer plus 4. A call also falls in this class, because it writes the return address to the stack and redirects the program counter on one edge. The bench checks this through the return address that the callee reads back from the top of the stack.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int REG_ID_W = 4;

  localparam logic [3:0] OPC_HALT = 4'h0;
  localparam logic [3:0] OPC_NOP  = 4'h1;
  localparam logic [3:0] OPC_MOVC = 4'h2;
  localparam logic [3:0] OPC_LDI  = 4'h3;
  localparam logic [3:0] OPC_ST   = 4'h4;
  localparam logic [3:0] OPC_LD   = 4'h5;
  localparam logic [3:0] OPC_ALU  = 4'h6;
  localparam logic [3:0] OPC_JMP  = 4'h7;
  localparam logic [3:0] OPC_CALL = 4'h8;
  localparam logic [3:0] OPC_RET  = 4'h9;
  localparam logic [3:0] OPC_PUSH = 4'hA;
  localparam logic [3:0] OPC_POP  = 4'hB;
  localparam logic [3:0] OPC_LDX  = 4'hC;

  localparam logic [3:0] REG_NONE = 4'hF;
  localparam logic [3:0] REG_SP   = 4'h4;

  localparam logic [1:0] ALU_ADD = 2'd0;
  localparam logic [1:0] ALU_SUB = 2'd1;
  localparam logic [1:0] ALU_AND = 2'd2;
  localparam logic [1:0] ALU_XOR = 2'd3;

  // ALU operand A source
  localparam logic [1:0] ASEL_REG   = 2'd0;
  localparam logic [1:0] ASEL_CONST = 2'd1;
  localparam logic [1:0] ASEL_PLUS  = 2'd2;
  localparam logic [1:0] ASEL_MINUS = 2'd3;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_BAD  = 2'd2
  } run_e;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu import cpu_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   fn,
  output logic [W-1:0] y,
  output flags_t       fl
);
  logic ovf;

  always_comb begin
    ovf = 1'b0;
    case (fn)
      ALU_ADD: begin
        y   = b_in + a_in;
        ovf = (a_in[W-1] == b_in[W-1]) && (y[W-1] != a_in[W-1]);
      end
      ALU_SUB: begin
        y   = b_in - a_in;
        ovf = (a_in[W-1] != b_in[W-1]) && (y[W-1] != b_in[W-1]);
      end
      ALU_AND: y = b_in & a_in;
      default: y = b_in ^ a_in;
    endcase
    fl.zf = (y == '0);
    fl.sf = y[W-1];
    fl.of = ovf;
  end
endmodule

// File: rtl/cpu_cond.sv
module cpu_cond import cpu_pkg::*; (
  input  logic [3:0] fn,
  input  flags_t     fl,
  output logic       ok
);
  logic lt;
  assign lt = fl.sf ^ fl.of;

  always_comb begin
    case (fn)
      4'd0:    ok = 1'b1;
      4'd1:    ok = lt | fl.zf;
      4'd2:    ok = lt;
      4'd3:    ok = fl.zf;
      4'd4:    ok = !fl.zf;
      4'd5:    ok = !lt;
      4'd6:    ok = !lt && !fl.zf;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile import cpu_pkg::*; #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_ID_W-1:0] rd_a_id,
  input  logic [REG_ID_W-1:0] rd_b_id,
  output logic [W-1:0]        rd_a,
  output logic [W-1:0]        rd_b,
  input  logic                wr_e_en,
  input  logic [REG_ID_W-1:0] wr_e_id,
  input  logic [W-1:0]        wr_e_data,
  input  logic                wr_m_en,
  input  logic [REG_ID_W-1:0] wr_m_id,
  input  logic [W-1:0]        wr_m_data
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [REG_ID_W-1:0] NREG_ID = REG_ID_W'(NREG);

  logic [W-1:0]    regs [NREG];
  logic [NREG-1:0] e_hit;
  logic [NREG-1:0] m_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign e_hit[g] = wr_e_en && (wr_e_id == REG_ID_W'(g));
    assign m_hit[g] = wr_m_en && (wr_m_id == REG_ID_W'(g));
  end

  // the memory-side write has priority when both ports name one register
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)           regs[i] <= '0;
      else if (m_hit[i]) regs[i] <= wr_m_data;
      else if (e_hit[i]) regs[i] <= wr_e_data;
    end
  end

  assign rd_a = (rd_a_id < NREG_ID) ? regs[rd_a_id[AW-1:0]] : '0;
  assign rd_b = (rd_b_id < NREG_ID) ? regs[rd_b_id[AW-1:0]] : '0;
endmodule

// File: rtl/cpu_decode.sv
module cpu_decode import cpu_pkg::*; #(
  parameter int W = 32
) (
  input  logic [8*(2+W/8)-1:0] fetch_bytes,
  output logic [3:0]           opc,
  output logic [3:0]           fn,
  output logic                 op_ok,
  output logic [2:0]           len,
  output logic [W-1:0]         cval,
  output logic [REG_ID_W-1:0]  src_a,
  output logic [REG_ID_W-1:0]  src_b,
  output logic [REG_ID_W-1:0]  dst_e,
  output logic [REG_ID_W-1:0]  dst_m,
  output logic [1:0]           a_sel,
  output logic                 b_zero,
  output logic [1:0]           alu_fn,
  output logic                 set_fl,
  output logic                 mem_wr,
  output logic                 addr_from_a,
  output logic                 wdata_seq,
  output logic                 cond_move
);
  logic [3:0] ra;
  logic [3:0] rb;

  assign opc  = fetch_bytes[7:4];
  assign fn   = fetch_bytes[3:0];
  assign ra   = fetch_bytes[15:12];
  assign rb   = fetch_bytes[11:8];
  // flow-control constants follow the opcode byte, others the register byte
  assign cval = (opc == OPC_JMP || opc == OPC_CALL) ? fetch_bytes[8 +: W]
                                                     : fetch_bytes[16 +: W];

  always_comb begin
    op_ok       = 1'b1;
    len         = 3'd1;
    src_a       = REG_NONE;
    src_b       = REG_NONE;
    dst_e       = REG_NONE;
    dst_m       = REG_NONE;
    a_sel       = ASEL_REG;
    b_zero      = 1'b0;
    alu_fn      = ALU_ADD;
    set_fl      = 1'b0;
    mem_wr      = 1'b0;
    addr_from_a = 1'b0;
    wdata_seq   = 1'b0;
    cond_move   = 1'b0;
    case (opc)
      OPC_HALT, OPC_NOP: len = 3'd1;
      OPC_MOVC: begin
        len = 3'd2; src_a = ra; b_zero = 1'b1; dst_e = rb;
        cond_move = 1'b1; op_ok = (fn <= 4'd6);
      end
      OPC_LDI: begin
        len = 3'd6; a_sel = ASEL_CONST; b_zero = 1'b1; dst_e = rb;
      end
      OPC_ST: begin
        len = 3'd6; src_a = ra; src_b = rb; a_sel = ASEL_CONST; mem_wr = 1'b1;
      end
      OPC_LD: begin
        len = 3'd6; src_b = rb; a_sel = ASEL_CONST; dst_m = ra;
      end
      OPC_ALU: begin
        len = 3'd2; src_a = ra; src_b = rb; alu_fn = fn[1:0];
        set_fl = 1'b1; dst_e = rb; op_ok = (fn <= 4'd3);
      end
      OPC_JMP: begin
        len = 3'd5; op_ok = (fn <= 4'd6);
      end
      OPC_CALL: begin
        len = 3'd5; src_b = REG_SP; a_sel = ASEL_MINUS; mem_wr = 1'b1;
        wdata_seq = 1'b1; dst_e = REG_SP;
      end
      OPC_RET: begin
        len = 3'd1; src_a = REG_SP; src_b = REG_SP; a_sel = ASEL_PLUS;
        addr_from_a = 1'b1; dst_e = REG_SP;
      end
      OPC_PUSH: begin
        len = 3'd2; src_a = ra; src_b = REG_SP; a_sel = ASEL_MINUS;
        mem_wr = 1'b1; dst_e = REG_SP;
      end
      OPC_POP: begin
        len = 3'd2; src_a = REG_SP; src_b = REG_SP; a_sel = ASEL_PLUS;
        addr_from_a = 1'b1; dst_e = REG_SP; dst_m = ra;
      end
      OPC_LDX: begin
        len = 3'd2; src_a = ra; src_b = rb; dst_m = rb;
      end
      default: op_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core import cpu_pkg::*; #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [W-1:0]         fetch_addr,
  input  logic [8*(2+W/8)-1:0] fetch_bytes,
  output logic [W-1:0]         data_addr,
  input  logic [W-1:0]         data_rdata,
  output logic                 data_we,
  output logic [W-1:0]         data_wdata,
  output logic [1:0]           run_state
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  logic [W-1:0] pc;
  run_e         st;
  flags_t       flags;

  logic [3:0]          opc, fn;
  logic                op_ok;
  logic [2:0]          len;
  logic [W-1:0]        cval;
  logic [REG_ID_W-1:0] src_a, src_b, dst_e_raw, dst_e, dst_m;
  logic [1:0]          a_sel, alu_fn;
  logic                b_zero, set_fl, mem_wr, addr_from_a, wdata_seq, cond_move;

  logic [W-1:0] val_a, val_b, alu_a, alu_b, alu_y, seq_pc, next_pc;
  flags_t       alu_fl;
  logic         cond_ok;
  logic         running, commit;

  cpu_decode #(.W(W)) u_dec (
    .fetch_bytes(fetch_bytes), .opc(opc), .fn(fn), .op_ok(op_ok), .len(len),
    .cval(cval), .src_a(src_a), .src_b(src_b), .dst_e(dst_e_raw), .dst_m(dst_m),
    .a_sel(a_sel), .b_zero(b_zero), .alu_fn(alu_fn), .set_fl(set_fl),
    .mem_wr(mem_wr), .addr_from_a(addr_from_a), .wdata_seq(wdata_seq),
    .cond_move(cond_move)
  );

  cpu_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .rd_a_id(src_a), .rd_b_id(src_b), .rd_a(val_a), .rd_b(val_b),
    .wr_e_en(commit), .wr_e_id(dst_e), .wr_e_data(alu_y),
    .wr_m_en(commit), .wr_m_id(dst_m), .wr_m_data(data_rdata)
  );

  cpu_cond u_cond (.fn(fn), .fl(flags), .ok(cond_ok));

  always_comb begin
    case (a_sel)
      ASEL_REG:   alu_a = val_a;
      ASEL_CONST: alu_a = cval;
      ASEL_PLUS:  alu_a = STEP;
      default:    alu_a = '0 - STEP;
    endcase
  end
  assign alu_b = b_zero ? '0 : val_b;

  cpu_alu #(.W(W)) u_alu (.a_in(alu_a), .b_in(alu_b), .fn(alu_fn), .y(alu_y), .fl(alu_fl));

  assign running = (st == ST_RUN);
  assign commit  = running && op_ok && (opc != OPC_HALT);
  assign dst_e   = (cond_move && !cond_ok) ? REG_NONE : dst_e_raw;
  assign seq_pc  = pc + W'(len);

  always_comb begin
    case (opc)
      OPC_JMP:  next_pc = cond_ok ? cval : seq_pc;
      OPC_CALL: next_pc = cval;
      OPC_RET:  next_pc = data_rdata;
      default:  next_pc = seq_pc;
    endcase
  end

  assign data_addr  = addr_from_a ? val_a : alu_y;
  assign data_wdata = wdata_seq ? seq_pc : val_a;
  assign data_we    = commit && mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      st    <= ST_RUN;
      flags <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
    end else if (running) begin
      if (!op_ok)                st <= ST_BAD;
      else if (opc == OPC_HALT)  st <= ST_HALT;
      else begin
        pc <= next_pc;
        if (set_fl) flags <= alu_fl;
      end
    end
  end

  assign fetch_addr = pc;
  assign run_state  = st;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] fetch_addr,
  input logic [1:0]   run_state,
  input logic         data_we,
  input logic [3:0]   opc,
  input logic         op_ok
);
  assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_addr == '0 && run_state == 2'd0));

  assert_nop_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0 && opc == 4'h1) |=> (fetch_addr == $past(fetch_addr) + W'(1)));

  assert_store_source_R6: assert property (@(posedge clk) disable iff (rst)
    data_we |-> (opc == 4'h4 || opc == 4'h8 || opc == 4'hA));

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (run_state != 2'd0) |=> ($stable(fetch_addr) && $stable(run_state)));

  assert_halt_enter_R10: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0 && opc == 4'h0) |=> (run_state == 2'd1));

  assert_bad_enter_R11: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0 && !op_ok) |=> (run_state == 2'd2));

  assert_no_write_stopped_R11: assert property (@(posedge clk) disable iff (rst)
    (run_state != 2'd0) |-> !data_we);
endmodule

bind cpu_core cpu_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .run_state(run_state),
  .data_we(data_we), .opc(opc), .op_ok(op_ok)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;
  localparam int MEM_N = 1024;
  localparam int MASK  = MEM_N - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_addr, data_addr, data_rdata, data_wdata;
  logic [47:0] fetch_bytes;
  logic        data_we;
  logic [1:0]  run_state;

  logic [7:0] mem  [MEM_N];
  logic [7:0] prog [MEM_N];
  logic       load_req = 1'b0;
  int         pp;
  int         nchk = 0;
  int         nerr = 0;

  always #10 clk = ~clk;

  cpu_core i_cpu_core (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_bytes(fetch_bytes),
    .data_addr(data_addr), .data_rdata(data_rdata), .data_we(data_we),
    .data_wdata(data_wdata), .run_state(run_state)
  );

  function automatic int wrap(input logic [31:0] a, input int k);
    return int'((a + 32'(k)) & 32'(MASK));
  endfunction

  always_comb begin
    for (int k = 0; k < 6; k++) fetch_bytes[8*k +: 8] = mem[wrap(fetch_addr, k)];
    for (int k = 0; k < 4; k++) data_rdata[8*k +: 8] = mem[wrap(data_addr, k)];
  end

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= prog[i];
    end else if (data_we) begin
      for (int k = 0; k < 4; k++) mem[wrap(data_addr, k)] <= data_wdata[8*k +: 8];
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  // spec-level condition table (R5)
  function automatic logic cnd(input int c, input logic z, input logic s, input logic o);
    case (c)
      0: return 1'b1;
      1: return (s ^ o) | z;
      2: return s ^ o;
      3: return z;
      4: return !z;
      5: return !(s ^ o);
      6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // small assembler
  task automatic new_prog();
    for (int i = 0; i < MEM_N; i++) prog[i] = 8'h00;
    pp = 0;
  endtask
  task automatic put8(input logic [7:0] b);
    prog[pp] = b; pp++;
  endtask
  task automatic put32(input logic [31:0] v);
    for (int k = 0; k < 4; k++) put8(v[8*k +: 8]);
  endtask
  task automatic a_ldi(input logic [31:0] v, input logic [3:0] rb);
    put8(8'h30); put8({4'hF, rb}); put32(v);
  endtask
  task automatic a_rr(input logic [7:0] op, input logic [3:0] ra, input logic [3:0] rb);
    put8(op); put8({ra, rb});
  endtask
  task automatic a_mem(input logic [7:0] op, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [31:0] d);
    put8(op); put8({ra, rb}); put32(d);
  endtask
  task automatic a_dst(input logic [7:0] op, input logic [31:0] d);
    put8(op); put32(d);
  endtask
  task automatic a_stk(input logic [7:0] op, input logic [3:0] ra);
    put8(op); put8({ra, 4'hF});
  endtask

  task automatic run_prog();
    int cyc;
    @(negedge clk); rst = 1'b1; load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    @(negedge clk); rst = 1'b0;
    cyc = 0;
    while (run_state == 2'd0 && cyc < 3000) begin
      @(negedge clk); cyc++;
    end
    if (cyc >= 3000) chk("run timeout", 32'(run_state), 32'd1);
  endtask

  typedef struct packed {
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        z;
    logic        s;
    logic        o;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{4'h0, 32'd5,         32'd7,         32'd12,        1'b0, 1'b0, 1'b0},
    '{4'h0, 32'h7FFFFFFF,  32'h00000001,  32'h80000000,  1'b0, 1'b1, 1'b1},
    '{4'h1, 32'd9,         32'd9,         32'd0,         1'b1, 1'b0, 1'b0},
    '{4'h1, 32'h00000001,  32'h80000000,  32'h7FFFFFFF,  1'b0, 1'b0, 1'b1},
    '{4'h2, 32'hF0F0F0F0,  32'h0FF00FF0,  32'h00F000F0,  1'b0, 1'b0, 1'b0},
    '{4'h3, 32'h80000001,  32'h00000001,  32'h80000000,  1'b0, 1'b1, 1'b0},
    '{4'h1, 32'd5,         32'd3,         32'hFFFFFFFE,  1'b0, 1'b1, 1'b0}
  };

  initial begin
    #(20ns * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] ret_addr;
    logic [31:0] frozen;

    // ALU vector table: result in rB, then flags through every condition
    for (int v = 0; v < 7; v++) begin
      new_prog();
      a_ldi(VEC[v].a, 4'd0);
      a_ldi(VEC[v].b, 4'd1);
      a_ldi(32'd1, 4'd2);
      a_rr({4'h6, VEC[v].fn}, 4'd0, 4'd1);
      a_mem(8'h40, 4'd1, 4'd7, 32'h200);
      for (int c = 0; c < 7; c++) begin
        a_ldi(32'd0, 4'd3);
        a_rr({4'h2, 4'(c)}, 4'd2, 4'd3);
        a_mem(8'h40, 4'd3, 4'd7, 32'(32'h204 + 4 * c));
      end
      put8(8'h00);
      run_prog();
      chk($sformatf("R3 vector %0d result", v), rd32(32'h200), VEC[v].r);
      for (int c = 0; c < 7; c++)
        chk($sformatf("R4 R5 vector %0d cond %0d", v, c), rd32(32'h204 + 4 * c),
            32'(cnd(c, VEC[v].z, VEC[v].s, VEC[v].o)));
    end

    // R1: reset state, flags zero=1 and registers cleared
    new_prog();
    a_ldi(32'd7, 4'd2);
    a_rr(8'h23, 4'd2, 4'd3);
    a_mem(8'h40, 4'd3, 4'd7, 32'h200);
    a_mem(8'h40, 4'd5, 4'd7, 32'h204);
    put8(8'h00);
    @(negedge clk); rst = 1'b1; load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    chk("R1 fetch_addr in reset", fetch_addr, 32'h0);
    chk("R1 run_state in reset", 32'(run_state), 32'd0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 20 && run_state == 2'd0; i++) @(negedge clk);
    chk("R1 zero flag set by reset", rd32(32'h200), 32'd7);
    chk("R1 register cleared by reset", rd32(32'h204), 32'd0);

    // R6: load with displacement, little-endian store, unaligned store
    new_prog();
    prog[32'h300] = 8'h11; prog[32'h301] = 8'h22; prog[32'h302] = 8'h33; prog[32'h303] = 8'h44;
    a_ldi(32'h2F0, 4'd1);
    a_mem(8'h50, 4'd0, 4'd1, 32'h10);
    a_mem(8'h40, 4'd0, 4'd7, 32'h200);
    a_mem(8'h40, 4'd0, 4'd7, 32'h221);
    put8(8'h00);
    run_prog();
    chk("R6 load word little-endian", rd32(32'h200), 32'h44332211);
    chk("R6 store low byte first", 32'(mem[32'h221]), 32'h11);
    chk("R6 store high byte last", 32'(mem[32'h224]), 32'h44);

    // R7: indexed load into rB, rA untouched
    new_prog();
    prog[32'h380] = 8'hBE; prog[32'h381] = 8'hBA; prog[32'h382] = 8'hFE; prog[32'h383] = 8'hCA;
    a_ldi(32'h300, 4'd0);
    a_ldi(32'h080, 4'd1);
    a_rr(8'hC0, 4'd0, 4'd1);
    a_mem(8'h40, 4'd1, 4'd7, 32'h200);
    a_mem(8'h40, 4'd0, 4'd7, 32'h204);
    put8(8'h00);
    run_prog();
    chk("R7 indexed load result", rd32(32'h200), 32'hCAFEBABE);
    chk("R7 base register kept", rd32(32'h204), 32'h300);

    // R8 and R9: push, pop, call, return, pop into stack pointer
    new_prog();
    a_ldi(32'h3F0, 4'd4);
    a_ldi(32'h55, 4'd0);
    a_stk(8'hA0, 4'd0);
    a_mem(8'h40, 4'd4, 4'd7, 32'h200);
    a_stk(8'hB0, 4'd1);
    a_mem(8'h40, 4'd1, 4'd7, 32'h204);
    a_mem(8'h40, 4'd4, 4'd7, 32'h208);
    a_dst(8'h80, 32'h100);
    ret_addr = 32'(pp);
    a_mem(8'h40, 4'd6, 4'd7, 32'h20C);
    a_stk(8'hA0, 4'd0);
    a_stk(8'hB0, 4'd4);
    a_mem(8'h40, 4'd4, 4'd7, 32'h210);
    put8(8'h00);
    pp = 32'h100;
    a_ldi(32'h77, 4'd6);
    a_mem(8'h50, 4'd5, 4'd4, 32'h0);
    a_mem(8'h40, 4'd5, 4'd7, 32'h214);
    put8(8'h90);
    run_prog();
    chk("R8 push lowers stack pointer", rd32(32'h200), 32'h3EC);
    chk("R8 pop returns pushed word", rd32(32'h204), 32'h55);
    chk("R8 pop restores stack pointer", rd32(32'h208), 32'h3F0);
    chk("R8 call pushes return address", rd32(32'h214), ret_addr);
    chk("R8 return resumes after call", rd32(32'h20C), 32'h77);
    chk("R9 pop into stack pointer keeps loaded word", rd32(32'h210), 32'h55);

    // R5 jumps, R2 lengths, R10 halt
    new_prog();
    a_ldi(32'd1, 4'd0);
    a_ldi(32'd1, 4'd1);
    a_rr(8'h61, 4'd0, 4'd1);
    a_dst(8'h74, 32'd30);
    a_ldi(32'hA, 4'd5);
    a_dst(8'h73, 32'd36);
    a_ldi(32'hBAD, 4'd5);
    a_mem(8'h40, 4'd5, 4'd7, 32'h200);
    a_dst(8'h70, 32'd53);
    a_ldi(32'hBAD, 4'd6);
    a_mem(8'h40, 4'd6, 4'd7, 32'h204);
    put8(8'h00);
    run_prog();
    chk("R5 not-taken then taken jump", rd32(32'h200), 32'hA);
    chk("R5 unconditional jump skips", rd32(32'h204), 32'h0);
    chk("R10 run_state halted", 32'(run_state), 32'd1);
    chk("R2 R10 pc rests on halt", fetch_addr, 32'd59);
    frozen = fetch_addr;
    repeat (8) @(negedge clk);
    chk("R10 pc frozen after halt", fetch_addr, frozen);
    chk("R10 state held after halt", 32'(run_state), 32'd1);

    // R11: undefined opcode
    new_prog();
    a_ldi(32'd5, 4'd0);
    a_mem(8'h40, 4'd0, 4'd7, 32'h200);
    put8(8'hD0);
    a_mem(8'h40, 4'd0, 4'd7, 32'h204);
    put8(8'h00);
    run_prog();
    repeat (4) @(negedge clk);
    chk("R11 run_state undefined opcode", 32'(run_state), 32'd2);
    chk("R11 pc frozen on bad opcode", fetch_addr, 32'd12);
    chk("R11 store before bad opcode", rd32(32'h200), 32'd5);
    chk("R11 no store after bad opcode", rd32(32'h204), 32'd0);

    // R11: out-of-range function on the ALU opcode
    new_prog();
    a_ldi(32'd5, 4'd0);
    a_rr(8'h64, 4'd0, 4'd0);
    a_mem(8'h40, 4'd0, 4'd7, 32'h200);
    put8(8'h00);
    run_prog();
    chk("R11 run_state bad function", 32'(run_state), 32'd2);
    chk("R11 pc on bad function", fetch_addr, 32'd6);
    chk("R11 nothing written after bad function", rd32(32'h200), 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule